// File: doc/BRIEF.md
# Multiplexed 4:2:2 Stream Demultiplexer

This block receives one multiplexed component video word per clock and splits the stream into three parallel channels: luma (Y), blue-difference chroma (Cb) and red-difference chroma (Cr). The words repeat as Cb, Y, Cr, Y. The first three words of each group are cosited samples. The fourth word is an isolated luma sample.

A single sync input sets the word phase. The block recognises sync high in one cycle followed by sync low in the next, and treats the word present in that second cycle as a Cb word. After that a two-bit phase counter runs freely. The sync pattern may be applied once, or repeated on every Cb word to re-align the phase each time. Each word is captured into its channel register, and a one-cycle valid pulse marks every new sample. The luma channel also carries a flag that tells whether the current Y sample is the one cosited with the chroma pair.

Every word is routed as picture data. This includes ancillary and timing-reference words: the block neither detects them nor replaces them. An 8-bit source is placed on the upper bits with the lower bits tied low, and the block passes it through as a full-width word.

Top module: `cmp422_split`

## Requirements
- R1: While reset is asserted, and on the cycle after it is released, all three channel outputs are zero, all valid strobes are low and the cosite flag is low.
- R2: Until the first sync event after reset, no valid strobe rises, whatever words arrive on the input.
- R3: A sync event is sync sampled high at one rising edge and low at the next. The word sampled at that second edge is a Cb word. It appears on `cb_out` with `cb_vld` high after that same edge.
- R4: After a Cb word, the next three words are taken as Y (with `y_cosited` = 1), Cr, and Y (with `y_cosited` = 0). Each sample is presented one clock after it is sampled.
- R5: Once synchronised, the phase keeps cycling through Cb, Y, Cr, Y with sync held low for any number of groups.
- R6: If the sync pattern is repeated on every Cb word (sync high on the preceding Y word), the alignment stays the same as when sync is held low.
- R7: A sync event in the middle of a group takes effect at once. The word at the event is taken as Cb even where the running count expected Y or Cr, and no error indication is given.
- R8: At most one of `cb_vld`, `y_vld`, `cr_vld` is high in any cycle. Each is a single-cycle pulse. In steady state Cb and Cr each pulse once every four clocks and Y pulses once every two clocks.
- R9: Channel data equals the input word bit for bit, including all-ones and all-zero timing-reference words and 8-bit words with the two low bits zero. A channel output holds its value in cycles where its valid is low.
- R10: Sync held high for several cycles establishes no phase. Only the high-to-low transition does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| word_in | input | DATA_W | Multiplexed 4:2:2 word |
| sync_in | input | 1 | Phase marker, high then low on the first Cb word |
| y_out | output | DATA_W | Luma sample |
| y_vld | output | 1 | One-cycle pulse when `y_out` is new |
| y_cosited | output | 1 | High when the current luma sample is cosited with the chroma pair |
| cb_out | output | DATA_W | Blue-difference chroma sample |
| cb_vld | output | 1 | One-cycle pulse when `cb_out` is new |
| cr_out | output | DATA_W | Red-difference chroma sample |
| cr_vld | output | 1 | One-cycle pulse when `cr_out` is new |

## Verification
The bench builds the block with the default word width of 10 bits. At this width the all-ones and all-zero reference words and 8-bit values on the upper bits can all be driven as real data, so the pass-through requirement is checked against extreme patterns. The sequences cover sync applied once, sync repeated on every Cb word, sync held high across several words, and a re-sync placed on a Cr slot. These put the free-running counter, the override path and the gating before lock into states where a wrong phase would show on the ports.

// File: rtl/cmp422_pkg.sv
package cmp422_pkg;

   localparam int NUM_PHASES = 4;
   localparam int NUM_LANES  = 3;

   typedef enum logic [1:0] {
      PH_CB = 2'd0,
      PH_YA = 2'd1,
      PH_CR = 2'd2,
      PH_YB = 2'd3
   } word_phase_t;

   // lane index: 0 = luma, 1 = Cb, 2 = Cr
   function automatic logic [NUM_PHASES-1:0] lane_phase_mask(input int lane);
      logic [NUM_PHASES-1:0] m;
      m = '0;
      case (lane)
         0:       begin m[PH_YA] = 1'b1; m[PH_YB] = 1'b1; end
         1:       m[PH_CB] = 1'b1;
         default: m[PH_CR] = 1'b1;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/cmp422_sync_edge.sv
module cmp422_sync_edge (
   input  logic clk,
   input  logic rst,
   input  logic sync_in,
   output logic realign
);
   logic sync_q;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= 1'b0;
      else     sync_q <= sync_in;
   end

   // falling edge of sync marks the current word as Cb
   assign realign = sync_q & ~sync_in;

   assert_realign_needs_high_R10: assert property (@(posedge clk) disable iff (rst)
      realign |-> $past(sync_in));

endmodule

// File: rtl/cmp422_phase_track.sv
module cmp422_phase_track
   import cmp422_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  logic        realign,
   output word_phase_t phase_now,
   output logic        active
);
   word_phase_t phase_q;
   logic        locked_q;

   always_comb begin
      phase_now = realign ? PH_CB : phase_q;
      active    = locked_q | realign;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q  <= PH_CB;
         locked_q <= 1'b0;
      end else begin
         phase_q <= word_phase_t'(phase_now + 2'd1);
         if (realign) locked_q <= 1'b1;
      end
   end

   assert_wrap_to_cb_R5: assert property (@(posedge clk) disable iff (rst)
      (active && phase_now == PH_YB) |=> (phase_now == PH_CB));

   assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (rst)
      active |=> active);

endmodule

// File: rtl/cmp422_lane.sv
module cmp422_lane
   import cmp422_pkg::*;
#(
   parameter int                    DATA_W     = 10,
   parameter logic [NUM_PHASES-1:0] PHASE_MASK = 4'b0001
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] word_in,
   input  logic              active,
   input  word_phase_t       phase_now,
   output logic [DATA_W-1:0] data_q,
   output logic              vld_q,
   output word_phase_t       phase_q
);
   logic take;
   assign take = active & PHASE_MASK[phase_now];

   always_ff @(posedge clk) begin
      if (rst) begin
         data_q  <= '0;
         vld_q   <= 1'b0;
         phase_q <= PH_CB;
      end else begin
         vld_q <= take;
         if (take) begin
            data_q  <= word_in;
            phase_q <= phase_now;
         end
      end
   end

   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
      !vld_q |-> $stable(data_q));

   assert_capture_exact_R9: assert property (@(posedge clk) disable iff (rst)
      take |=> (data_q == $past(word_in)));

endmodule

// File: rtl/cmp422_split.sv
module cmp422_split
   import cmp422_pkg::*;
#(
   parameter int DATA_W = 10
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] word_in,
   input  logic              sync_in,
   output logic [DATA_W-1:0] y_out,
   output logic              y_vld,
   output logic              y_cosited,
   output logic [DATA_W-1:0] cb_out,
   output logic              cb_vld,
   output logic [DATA_W-1:0] cr_out,
   output logic              cr_vld
);
   localparam int LANE_Y  = 0;
   localparam int LANE_CB = 1;
   localparam int LANE_CR = 2;

   initial begin
      assert (DATA_W >= 2)
         else $error("DATA_W must be at least 2");
   end

   logic        realign;
   logic        active;
   word_phase_t phase_now;

   logic [DATA_W-1:0] lane_data [NUM_LANES];
   logic              lane_vld  [NUM_LANES];
   word_phase_t       lane_ph   [NUM_LANES];

   cmp422_sync_edge u_sync (
      .clk     (clk),
      .rst     (rst),
      .sync_in (sync_in),
      .realign (realign)
   );

   cmp422_phase_track u_phase (
      .clk       (clk),
      .rst       (rst),
      .realign   (realign),
      .phase_now (phase_now),
      .active    (active)
   );

   for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      localparam logic [NUM_PHASES-1:0] MASK = lane_phase_mask(g);
      cmp422_lane #(
         .DATA_W     (DATA_W),
         .PHASE_MASK (MASK)
      ) u_lane (
         .clk       (clk),
         .rst       (rst),
         .word_in   (word_in),
         .active    (active),
         .phase_now (phase_now),
         .data_q    (lane_data[g]),
         .vld_q     (lane_vld[g]),
         .phase_q   (lane_ph[g])
      );
   end

   assign y_out     = lane_data[LANE_Y];
   assign y_vld     = lane_vld[LANE_Y];
   assign y_cosited = lane_vld[LANE_Y] & (lane_ph[LANE_Y] == PH_YA);
   assign cb_out    = lane_data[LANE_CB];
   assign cb_vld    = lane_vld[LANE_CB];
   assign cr_out    = lane_data[LANE_CR];
   assign cr_vld    = lane_vld[LANE_CR];

   assert_one_strobe_R8: assert property (@(posedge clk) disable iff (rst)
      $onehot0({cb_vld, y_vld, cr_vld}));

   assert_no_strobe_unlocked_R2: assert property (@(posedge clk) disable iff (rst)
      !active |=> !(cb_vld || y_vld || cr_vld));

   assert_cb_on_realign_R3: assert property (@(posedge clk) disable iff (rst)
      realign |=> cb_vld);

   assert_cosite_after_cb_R4: assert property (@(posedge clk) disable iff (rst)
      (cb_vld && !realign) |=> (y_vld && y_cosited));

   assert_cr_after_cosite_R4: assert property (@(posedge clk) disable iff (rst)
      (y_cosited && !realign) |=> cr_vld);

endmodule

// File: tb/cmp422_split_bench.sv
module cmp422_split_bench;
   localparam int W = 10;

   logic         clk = 1'b0;
   logic         rst;
   logic [W-1:0] word_in;
   logic         sync_in;
   logic [W-1:0] y_out, cb_out, cr_out;
   logic         y_vld, y_cosited, cb_vld, cr_vld;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #2 clk = ~clk;

   cmp422_split #(.DATA_W(W)) u_cmp422_split (
      .clk(clk), .rst(rst), .word_in(word_in), .sync_in(sync_in),
      .y_out(y_out), .y_vld(y_vld), .y_cosited(y_cosited),
      .cb_out(cb_out), .cb_vld(cb_vld), .cr_out(cr_out), .cr_vld(cr_vld)
   );

   task automatic chk(input string tag, input bit ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one word and sample just after the next rising edge
   task automatic drive(input logic [W-1:0] w, input logic s);
      @(negedge clk);
      word_in = w;
      sync_in = s;
      @(posedge clk);
      #1;
   endtask

   // kind: 0 none, 1 Cb, 2 Y cosited, 3 Cr, 4 Y isolated
   task automatic feed(input string tag, input logic [W-1:0] w, input logic s, input int kind);
      logic [2:0] ev;
      drive(w, s);
      case (kind)
         1: ev = 3'b100;
         2, 4: ev = 3'b010;
         3: ev = 3'b001;
         default: ev = 3'b000;
      endcase
      chk({tag, " strobes"}, {cb_vld, y_vld, cr_vld} == ev, {cb_vld, y_vld, cr_vld}, ev);
      if (kind == 1) chk({tag, " cb data"}, cb_out == w, cb_out, w);
      if (kind == 3) chk({tag, " cr data"}, cr_out == w, cr_out, w);
      if (kind == 2 || kind == 4) begin
         chk({tag, " y data"}, y_out == w, y_out, w);
         chk({tag, " cosite"}, y_cosited == (kind == 2), y_cosited, kind == 2);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sync_in = 1'b0; word_in = '0;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 outs in reset", {y_out, cb_out, cr_out} == '0, y_out | cb_out | cr_out, 0);
      chk("R1 strobes in reset", {y_vld, cb_vld, cr_vld, y_cosited} == 4'b0,
          {y_vld, cb_vld, cr_vld, y_cosited}, 0);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk); #1;
      chk("R1 after release", {y_vld, cb_vld, cr_vld} == 3'b0 && cb_out == '0,
          {y_vld, cb_vld, cr_vld}, 0);
   endtask

   task automatic t_prelock();
      for (int i = 0; i < 6; i++) feed("R2 prelock", W'(10'h155 + i), 1'b0, 0);
      // sync held high: no event (R10)
      for (int i = 0; i < 4; i++) feed("R10 held high", W'(10'h0AA + i), 1'b1, 0);
   endtask

   // one group; sync on the Y before the next Cb when tog is set
   task automatic group(input string tag, input int base, input bit tog);
      feed({tag, " Cb"}, W'(base),     1'b0, 1);
      feed({tag, " Ya"}, W'(base + 1), 1'b0, 2);
      chk("R9 cb holds", cb_out == W'(base), cb_out, base);
      feed({tag, " Cr"}, W'(base + 2), 1'b0, 3);
      feed({tag, " Yb"}, W'(base + 3), tog, 4);
   endtask

   task automatic t_sync_once();
      // sync just went high in t_prelock; falling edge now on Cb
      group("R3 first", 10'h040, 1'b0);
      for (int g = 0; g < 3; g++) group("R5 free run", 10'h100 + 16 * g, 1'b0);
   endtask

   task automatic t_toggle();
      feed("R6 pre", 10'h200, 1'b0, 1);
      feed("R6 pre", 10'h201, 1'b0, 2);
      feed("R6 pre", 10'h202, 1'b0, 3);
      feed("R6 pre", 10'h203, 1'b1, 4);
      for (int g = 0; g < 3; g++) group("R6 toggle", 10'h210 + 16 * g, 1'b1);
      group("R6 tail", 10'h260, 1'b0);
   endtask

   task automatic t_override();
      feed("R7 Cb", 10'h300, 1'b0, 1);
      feed("R7 Ya", 10'h301, 1'b1, 2);
      // event here: expected Cr, taken as Cb
      feed("R7 override", 10'h302, 1'b0, 1);
      feed("R7 Ya", 10'h303, 1'b0, 2);
      feed("R7 Cr", 10'h304, 1'b0, 3);
      feed("R7 Yb", 10'h305, 1'b0, 4);
   endtask

   task automatic t_raw_words();
      // timing-reference pattern and 8-bit data routed as picture data
      feed("R9 ones", 10'h3FF, 1'b0, 1);
      feed("R9 zero", 10'h000, 1'b0, 2);
      feed("R9 zero", 10'h000, 1'b0, 3);
      feed("R9 8bit", 10'h2AC, 1'b0, 4);
      feed("R9 8bit", 10'h3FC, 1'b0, 1);
      feed("R9 8bit", 10'h004, 1'b0, 2);
      feed("R9 ones", 10'h3FF, 1'b0, 3);
      chk("R9 cb holds", cb_out == 10'h3FC, cb_out, 10'h3FC);
      feed("R8 cadence", 10'h111, 1'b0, 4);
   endtask

   task automatic t_reset_mid();
      do_reset();
      for (int i = 0; i < 5; i++) feed("R2 after reset", W'(10'h0F0 + i), 1'b0, 0);
      feed("R3 relock high", 10'h0E0, 1'b1, 0);
      group("R3 relock", 10'h0C0, 1'b0);
   endtask

   initial begin
      rst = 1'b1; sync_in = 1'b0; word_in = '0;
      do_reset();
      t_prelock();
      t_sync_once();
      t_toggle();
      t_override();
      t_raw_words();
      t_reset_mid();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule